// File: doc/BRIEF.md
# I-Structure Cell State Controller

This block runs one internal command per cycle against a store of 1024 cells, each holding a 16-bit word and a 2-bit presence state (empty, reserved, full or waiting). It gives producer/consumer synchronisation without locks. A read of a cell that has not been written yet is parked in a single deferred-read slot. The first write to that cell then completes the read. Each command carries a 16-bit word. For writes that word is the data. For the reading commands it is an opaque return template, which comes back as the head flit of the result token.

A result token is two flits: a head (the return template) and a body (a data word). Both appear on the cycle after the command is accepted. When a parked read cannot be taken, the command input stalls through `cmd_ready`. A write over a full cell raises a one-cycle diagnostic pulse. The atomic step commands reach only the lower 256 cells. A source may withdraw a command that has not been accepted.

Top module: `istruct_cell_ctrl`

## Requirements
- R1: After synchronous active-low reset every cell is empty, the deferred-read slot is free, `res_valid` and `ovw_pulse` are low and `cmd_ready` is high.
- R2: A read (op 0) of a full cell gives, one cycle after acceptance, a token with head = the command word and body = the cell data; the cell stays full.
- R3: A read (op 0) of an empty or reserved cell emits nothing, makes the cell waiting and saves the address and command word in the slot. A later write to that same address emits a token with head = the saved word and body = the written data, and frees the slot. Writes to other addresses do not complete it.
- R4: `cmd_ready` is low, and the command is not taken, for a read of a waiting cell and for a read of an empty or reserved cell while the slot is occupied.
- R5: A write (op 1) to an empty or reserved cell stores the data and makes it full, with no token and no pulse.
- R6: A write (op 1) to a full cell replaces the data, raises `ovw_pulse` for one cycle and emits no token.
- R7: Free (op 3) and clear (op 4) make any cell empty and never emit a token. On a waiting cell they cancel the parked read, so a later write to it emits nothing.
- R8: Alloc (op 2) turns an empty cell reserved and leaves cells in any other state unchanged; it emits nothing.
- R9: Peek (op 5) always emits a token with head = command word. Its body is the cell data with `res_empty` low if the cell is full. Otherwise its body is 0 with `res_empty` high. It never parks.
- R10: Step-up (op 6) and step-down (op 7) use only the low 8 address bits. On a full cell they return the old data and write back old+1 or old-1 modulo 2^16.
- R11: Step-up or step-down on a cell that is not full emits a token with body 16'hFFFF and `res_err` high, and leaves the cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 read … 7 step-down) |
| cmd_addr | input | 10 | Cell address |
| cmd_word | input | 16 | Write data or return template |
| res_valid | output | 1 | Result token present |
| res_head | output | 16 | Token head flit (template) |
| res_body | output | 16 | Token body flit (data) |
| res_empty | output | 1 | Peek found the cell not full |
| res_err | output | 1 | Step command hit a cell that is not full |
| ovw_pulse | output | 1 | Write replaced a full cell |

## Verification
The hardest situation to reach is a second parked read while the slot is taken. With one command stream, a stalled read would block the very write that frees the slot. The stimulus therefore offers the read, watches `cmd_ready` stay low for several cycles and then withdraws it. It then sends a write to an unrelated cell (no token expected), then the releasing write, and offers the read again to see it park. A sweep over every command against every starting presence state sets up each state first: waiting is reached through a parked read. After each command the cell is cleared and rewritten, which shows whether a cancelled read stays silent.

// File: rtl/istruct_pkg.sv
// Shared types for the I-structure cell controller.
// Assumes: presence codes are fixed two-bit values; command codes are three bits.
package istruct_pkg;

    localparam int CELL_AW = 10;
    localparam int WORD_W  = 16;
    localparam int STEP_AW = 8;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_RSVD  = 2'b01,
        ST_FULL  = 2'b10,
        ST_WAIT  = 2'b11
    } cell_state_e;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ALLOC = 3'd2,
        OP_FREE  = 3'd3,
        OP_CLEAR = 3'd4,
        OP_PEEK  = 3'd5,
        OP_STUP  = 3'd6,
        OP_STDN  = 3'd7
    } cmd_op_e;

endpackage

// File: rtl/istruct_cell_store.sv
// Cell store: a word array and a presence array sharing one address.
// Reads are combinational, so the caller can do its read-modify-write in one cycle.
// Writes happen at the clock edge.
// Assumes: only presence is reset (all empty); word contents are don't-care until written.
module istruct_cell_store
    import istruct_pkg::*;
#(
    parameter int ADDR_W = CELL_AW,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output cell_state_e       st_o,
    output logic [DATA_W-1:0] dat_o,
    input  logic              st_we_i,
    input  cell_state_e       st_i,
    input  logic              dat_we_i,
    input  logic [DATA_W-1:0] dat_i
);
    localparam int DEPTH = 1 << ADDR_W;

    cell_state_e       st_mem  [DEPTH];
    logic [DATA_W-1:0] dat_mem [DEPTH];

    assign st_o  = st_mem[addr_i];
    assign dat_o = dat_mem[addr_i];

    // Presence array: cleared to empty on reset, updated on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_mem[i] <= ST_EMPTY;
        end else if (st_we_i) begin
            st_mem[addr_i] <= st_i;
        end
    end

    // Word array: written on request, never reset.
    always_ff @(posedge clk) begin
        if (dat_we_i) dat_mem[addr_i] <= dat_i;
    end

endmodule

// File: rtl/istruct_defer_slot.sv
// Single deferred-read slot: holds a valid flag, the parked cell address and the return template.
// It reports whether the looked-up address is the parked one.
// Assumes: set is requested only while free; set and clear never coincide.
module istruct_defer_slot #(
    parameter int ADDR_W = 10,
    parameter int TMPL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TMPL_W-1:0] tmpl_i,
    output logic              valid_o,
    output logic              hit_o,
    output logic [TMPL_W-1:0] tmpl_o
);
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TMPL_W-1:0] tmpl_q;

    // Valid flag: set when a read parks, dropped when released or cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= 1'b0;
        else if (set_i) valid_q <= 1'b1;
        else if (clr_i) valid_q <= 1'b0;
    end

    // Entry payload: captured with the set request.
    always_ff @(posedge clk) begin
        if (set_i) begin
            addr_q <= addr_i;
            tmpl_q <= tmpl_i;
        end
    end

    assign valid_o = valid_q;
    assign hit_o   = valid_q && (addr_q == addr_i);
    assign tmpl_o  = tmpl_q;

    assert_single_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> !valid_q);

    assert_park_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (valid_q && addr_q == $past(addr_i) && tmpl_q == $past(tmpl_i)));

    assert_release_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !valid_q);

endmodule

// File: rtl/istruct_step_unit.sv
// Wrapping plus-or-minus-one unit for the atomic step commands.
// Assumes: the result wraps modulo 2^DATA_W.
module istruct_step_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              down_i,
    output logic [DATA_W-1:0] val_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Add or subtract one.
    always_comb val_o = down_i ? (val_i - ONE) : (val_i + ONE);

endmodule

// File: rtl/istruct_cell_ctrl.sv
// I-structure cell controller top.
// Decodes one command per cycle against the addressed cell's presence state.
// Does the state read-modify-write in that same cycle.
// Parks at most one blocked read and registers result tokens and the overwrite pulse.
// Assumes: the command source may withdraw an unaccepted command; step commands use only
// the low STEP_W address bits.
module istruct_cell_ctrl
    import istruct_pkg::*;
#(
    parameter int ADDR_W = CELL_AW,
    parameter int DATA_W = WORD_W,
    parameter int STEP_W = STEP_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_word,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_head,
    output logic [DATA_W-1:0] res_body,
    output logic              res_empty,
    output logic              res_err,
    output logic              ovw_pulse
);
    localparam int PAD_W = ADDR_W - STEP_W;

    cmd_op_e           op;
    logic              is_step;
    logic [ADDR_W-1:0] eff_addr;
    cell_state_e       st;
    logic [DATA_W-1:0] dat;
    logic [DATA_W-1:0] stepped;
    logic              dr_valid, dr_hit;
    logic [DATA_W-1:0] dr_tmpl;
    logic              park_need, stall, go;

    logic              tok, tok_empty, tok_err, ovw;
    logic [DATA_W-1:0] tok_head, tok_body;
    logic              st_we, dat_we, dr_set, dr_clr;
    cell_state_e       st_new;

    assign op       = cmd_op_e'(cmd_op);
    assign is_step  = (op == OP_STUP) || (op == OP_STDN);
    assign eff_addr = is_step ? {{PAD_W{1'b0}}, cmd_addr[STEP_W-1:0]} : cmd_addr;

    istruct_cell_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .addr_i(eff_addr),
        .st_o(st), .dat_o(dat),
        .st_we_i(st_we), .st_i(st_new),
        .dat_we_i(dat_we), .dat_i(is_step ? stepped : cmd_word)
    );

    istruct_defer_slot #(.ADDR_W(ADDR_W), .TMPL_W(DATA_W)) i_slot (
        .clk(clk), .rst_n(rst_n), .set_i(dr_set), .clr_i(dr_clr),
        .addr_i(eff_addr), .tmpl_i(cmd_word),
        .valid_o(dr_valid), .hit_o(dr_hit), .tmpl_o(dr_tmpl)
    );

    istruct_step_unit #(.DATA_W(DATA_W)) i_step (
        .val_i(dat), .down_i(op == OP_STDN), .val_o(stepped)
    );

    // Back-pressure: a read that cannot park, or that targets an already-waiting cell.
    always_comb begin
        park_need = (op == OP_READ) && (st == ST_EMPTY || st == ST_RSVD);
        stall     = ((op == OP_READ) && (st == ST_WAIT)) || (park_need && dr_valid);
        cmd_ready = !stall;
        go        = cmd_valid && !stall;
    end

    // Command decode: presence transition, data update, slot action and token content.
    always_comb begin
        tok = 1'b0; tok_empty = 1'b0; tok_err = 1'b0; ovw = 1'b0;
        tok_head = cmd_word; tok_body = '0;
        st_we = 1'b0; dat_we = 1'b0; dr_set = 1'b0; dr_clr = 1'b0;
        st_new = st;
        if (go) begin
            unique case (op)
                OP_READ: begin
                    if (st == ST_FULL) begin
                        tok = 1'b1; tok_body = dat;
                    end else begin
                        dr_set = 1'b1; st_we = 1'b1; st_new = ST_WAIT;
                    end
                end
                OP_WRITE: begin
                    dat_we = 1'b1; st_we = 1'b1; st_new = ST_FULL;
                    if (st == ST_WAIT && dr_hit) begin
                        tok = 1'b1; tok_head = dr_tmpl; tok_body = cmd_word; dr_clr = 1'b1;
                    end
                    ovw = (st == ST_FULL);
                end
                OP_ALLOC: begin
                    if (st == ST_EMPTY) begin
                        st_we = 1'b1; st_new = ST_RSVD;
                    end
                end
                OP_FREE, OP_CLEAR: begin
                    st_we = 1'b1; st_new = ST_EMPTY;
                    dr_clr = (st == ST_WAIT) && dr_hit;
                end
                OP_PEEK: begin
                    tok = 1'b1;
                    tok_empty = (st != ST_FULL);
                    tok_body  = (st == ST_FULL) ? dat : '0;
                end
                OP_STUP, OP_STDN: begin
                    tok = 1'b1;
                    if (st == ST_FULL) begin
                        tok_body = dat; dat_we = 1'b1;
                    end else begin
                        tok_body = '1; tok_err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Result and diagnostic registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0; res_empty <= 1'b0; res_err <= 1'b0; ovw_pulse <= 1'b0;
            res_head  <= '0;   res_body  <= '0;
        end else begin
            res_valid <= tok;  res_empty <= tok_empty; res_err <= tok_err; ovw_pulse <= ovw;
            res_head  <= tok_head; res_body <= tok_body;
        end
    end

    assert_wait_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && st == ST_WAIT) |-> dr_hit);

    assert_park_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && park_need) |=> !res_valid);

    assert_release_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == OP_WRITE && dr_hit) |=>
            (res_valid && res_head == $past(dr_tmpl) && res_body == $past(cmd_word)));

    assert_ovw_no_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_pulse |-> !res_valid);

    assert_silent_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (op == OP_FREE || op == OP_CLEAR || op == OP_ALLOC)) |=> !res_valid);

    assert_step_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && is_step && st == ST_FULL) |=> (res_valid && res_body == $past(dat) && !res_err));

    assert_err_body_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> (res_valid && res_body == '1));

endmodule

// File: tb/test_istruct_cell_ctrl.sv
// Self-checking bench: a presence/data model written from the requirements predicts every token, pulse and stall.
module test_istruct_cell_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_AL = 3'd2, C_FR = 3'd3,
                           C_CL = 3'd4, C_PK = 3'd5, C_UP = 3'd6, C_DN = 3'd7;
    localparam logic [1:0] M_E = 2'd0, M_R = 2'd1, M_F = 2'd2, M_W = 2'd3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [9:0]  cmd_addr = '0;
    logic [15:0] cmd_word = '0;
    logic        res_valid, res_empty, res_err, ovw_pulse;
    logic [15:0] res_head, res_body;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [1:0]  ms [1024];
    logic [15:0] md [1024];
    bit          dv = 0;
    int          da = 0;
    logic [15:0] dt = '0;

    istruct_cell_ctrl i_istruct_cell_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_word(cmd_word),
        .res_valid(res_valid), .res_head(res_head), .res_body(res_body),
        .res_empty(res_empty), .res_err(res_err), .ovw_pulse(ovw_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Issue one command; the model predicts stall or result, then is updated.
    task automatic run(logic [2:0] op, int addr, logic [15:0] w);
        int ea;
        logic [1:0] s;
        logic [15:0] d, eh, eb;
        bit ev, ee, er, eo, st;
        string tag;
        logic [35:0] act, exp;
        ea = (op == C_UP || op == C_DN) ? (addr & 255) : addr;
        s = ms[ea]; d = md[ea];
        ev = 0; ee = 0; er = 0; eo = 0; st = 0; eh = w; eb = '0; tag = "R1";
        case (op)
            C_RD: if (s == M_F) begin ev = 1; eb = d; tag = "R2"; end
                  else if (s == M_W || dv) begin st = 1; tag = "R4"; end
                  else begin dv = 1; da = ea; dt = w; ms[ea] = M_W; tag = "R3"; end
            C_WR: begin
                tag = (s == M_F) ? "R6" : "R5";
                if (s == M_W) begin ev = 1; eh = dt; eb = w; dv = 0; tag = "R3"; end
                eo = (s == M_F); md[ea] = w; ms[ea] = M_F;
            end
            C_AL: begin tag = "R8"; if (s == M_E) ms[ea] = M_R; end
            C_FR, C_CL: begin tag = "R7"; if (s == M_W) dv = 0; ms[ea] = M_E; end
            C_PK: begin tag = "R9"; ev = 1; ee = (s != M_F); eb = (s == M_F) ? d : 16'h0; end
            default: begin
                ev = 1;
                if (s == M_F) begin
                    tag = "R10"; eb = d;
                    md[ea] = (op == C_UP) ? d + 16'd1 : d - 16'd1;
                end else begin tag = "R11"; eb = 16'hFFFF; er = 1; end
            end
        endcase
        cmd_valid = 1; cmd_op = op; cmd_addr = 10'(addr); cmd_word = w;
        #1;
        if (st) begin
            chk(!cmd_ready, tag, {35'd0, cmd_ready}, 36'd0);
            repeat (3) @(negedge clk);
            chk(!cmd_ready && !res_valid, tag, {34'd0, cmd_ready, res_valid}, 36'd0);
            cmd_valid = 0;
        end else begin
            chk(cmd_ready, tag, {35'd0, cmd_ready}, 36'd1);
            @(posedge clk); @(negedge clk);
            cmd_valid = 0;
            act = {res_valid, res_empty, res_err, ovw_pulse,
                   res_valid ? res_head : 16'h0, res_valid ? res_body : 16'h0};
            exp = {ev, ee, er, eo, ev ? eh : 16'h0, ev ? eb : 16'h0};
            chk(act == exp, tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin ms[i] = M_E; md[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: idle outputs after reset
        chk(!res_valid && !ovw_pulse && cmd_ready, "R1",
            {33'd0, res_valid, ovw_pulse, cmd_ready}, 36'd1);
        @(negedge clk);

        // R1/R9: every sampled cell starts empty
        for (int a = 0; a < 1024; a += 31) run(C_PK, a, 16'(a));

        // R5, R2, R9, R6 across the address range
        for (int a = 3; a < 1024; a += 29) begin
            run(C_WR, a, 16'(a * 7 + 1));
            run(C_RD, a, 16'h8000 | 16'(a));
            run(C_PK, a, 16'h4000 | 16'(a));
            run(C_WR, a, 16'(a * 5 + 2));
            run(C_RD, a, 16'h2000);
            run(C_CL, a, 16'h0);
        end

        // Every command against every starting presence state (R2..R11)
        for (int op = 0; op < 8; op++) begin
            for (int s = 0; s < 4; s++) begin
                int a;
                a = 40 + op * 4 + s;
                run(C_CL, a, 16'h0);
                if (s == 1) run(C_AL, a, 16'h0);
                if (s == 2) run(C_WR, a, 16'h1230 + 16'(op));
                if (s == 3) run(C_RD, a, 16'hA500 + 16'(op));
                run(3'(op), a, 16'h7700 + 16'(s));
                run(C_PK, a, 16'h0);
                run(C_CL, a, 16'h0);
                run(C_WR, a, 16'h0BAD);
                run(C_RD, a, 16'h00C0);
                run(C_CL, a, 16'h0);
            end
        end

        // R4: second park stalls until the first is released
        run(C_RD, 600, 16'hCAFE);
        run(C_RD, 700, 16'hBEEF);
        run(C_AL, 700, 16'h0);
        run(C_RD, 700, 16'hBEEF);
        run(C_WR, 601, 16'h1111);
        run(C_WR, 600, 16'h2222);
        run(C_RD, 700, 16'hBEEF);
        run(C_RD, 700, 16'hF00D);
        run(C_WR, 700, 16'h3333);
        run(C_RD, 700, 16'h0001);

        // R10: step commands alias the upper address bits and wrap
        run(C_WR, 5, 16'd10);
        run(C_UP, 256 + 5, 16'h0055);
        run(C_UP, 768 + 5, 16'h0056);
        run(C_RD, 5, 16'h0057);
        for (int k = 0; k < 14; k++) run(C_DN, 5, 16'(k));
        run(C_PK, 5, 16'h0058);
        run(C_WR, 9, 16'hFFFF);
        run(C_UP, 9, 16'h0);
        run(C_PK, 9, 16'h0);
        run(C_DN, 9, 16'h0);
        run(C_PK, 9, 16'h0);
        run(C_CL, 9, 16'h0);
        run(C_DN, 512 + 9, 16'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule